// File: doc/BRIEF.md
# Chained Nibble-to-Byte Queue Pair

This block builds a byte-wide output queue out of two nibble-wide, equal-depth synchronous queues on one clock. Nibbles arrive on a single narrow input and always enter the first queue. Whenever the first queue holds data and the second queue has room, a sequencer pops the first queue and pushes that nibble into the second queue in the same cycle. Once the second queue is full, it is left alone and the first queue keeps filling until it is full too.

With both queues full, the block switches to draining. Each accepted read pops both queues together and forms one byte from them: the first queue's nibble is the upper half and the second queue's nibble is the lower half. One combined full flag and one combined empty flag describe the pair as a whole. Input writes are refused while draining, until both queues are empty again. At that point a new batch may start.

The sequencer has three phases: transfer, fill and drain. In the transfer phase an input write and an internal transfer can happen in the same cycle, so a burst of back-to-back input writes is never stalled.

Top module: `nib2byte_chain`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, the block shows `empty`=1, `full`=0 and `rd_data`=0, and any stored nibbles are discarded.
- R2: The first DEPTH nibbles accepted after the pair is empty move into the second queue. The k-th byte read (counting from 0) is {nibble DEPTH+k in bits [7:4], nibble k in bits [3:0]}.
- R3: `full` is 1 only when both queues hold DEPTH nibbles. After 2*DEPTH-1 accepted nibbles it is 0, and after 2*DEPTH it is 1.
- R4: An input write is refused while the first queue is full, and while draining until both queues are empty. A refused nibble never appears in any output byte.
- R5: A read accepted while draining (or while `full`=1) pops one nibble from each queue. The new byte is on `rd_data` after that clock edge, and `rd_data` holds its value in every cycle without an accepted read.
- R6: A read request made before the pair is full is ignored: `rd_data` is unchanged and no nibble is removed.
- R7: `empty` becomes 1 after the edge of the read that removes the last pair. An input write is accepted from the very next cycle.
- R8: A read request while `empty`=1 is ignored, and `rd_data` keeps the last byte.
- R9: During transfer an input write and a transfer may share a cycle. 2*DEPTH writes on consecutive cycles from empty are all accepted, and `full`=1 right after the last of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for both queues and the sequencer |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Input nibble write request |
| wr_data | input | NIB_W | Input nibble |
| rd_en | input | 1 | Byte read request |
| rd_data | output | 2*NIB_W | Registered output byte, upper half from the first queue |
| full | output | 1 | Both queues full |
| empty | output | 1 | Both queues empty |

## Verification
Every result of this block is due right after the clock edge that accepts the request. An accepted write changes `full`/`empty` after that edge. An accepted read loads `rd_data` at that edge. A transfer adds one cycle of latency: a nibble written in cycle t can move to the second queue at edge t+1 at the earliest.

The bench drives inputs after a falling edge, lets exactly one rising edge pass, and samples all outputs at the following falling edge. The expected value for each check is therefore the state after the single edge that consumed the stimulus. The bench runs with DEPTH=4 so that a complete fill-and-drain cycle fits in a short vector table. Directed sequences then cover refused writes, ignored reads, reset in mid-stream and an immediate restart after draining.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
  typedef enum logic [1:0] {
    PH_XFER  = 2'd0,
    PH_FILL  = 2'd1,
    PH_DRAIN = 2'd2
  } nbc_phase_e;
endpackage

// File: rtl/nbc_fifo.sv
module nbc_fifo #(
  parameter int W     = 4,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];
  assign level   = cnt;

  // storage kept free of reset so it can map to memory
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R4: a push into a full queue leaves the fill level alone
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> $stable(cnt));
  // R8: a pop from an empty queue leaves the fill level alone
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> $stable(cnt));
  p_level_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/nbc_seq.sv
module nbc_seq
  import nbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_req,
  input  logic       rd_req,
  input  logic       a_full,
  input  logic       a_empty,
  input  logic       b_full,
  input  logic       b_empty,
  output logic       a_push,
  output logic       move,
  output logic       pop_pair,
  output nbc_phase_e phase
);
  nbc_phase_e phase_q;
  logic       both_empty, both_full;

  assign both_empty = a_empty && b_empty;
  assign both_full  = a_full && b_full;
  assign phase      = phase_q;

  always_comb begin
    a_push   = wr_req && !a_full && ((phase_q != PH_DRAIN) || both_empty);
    move     = (phase_q == PH_XFER) && !a_empty && !b_full;
    pop_pair = rd_req && ((phase_q == PH_DRAIN) || both_full) && !a_empty && !b_empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_XFER;
    end else begin
      case (phase_q)
        PH_XFER:  if (b_full) phase_q <= PH_FILL;
        PH_FILL:  if (a_full) phase_q <= PH_DRAIN;
        PH_DRAIN: if (both_empty) phase_q <= PH_XFER;
        default:  phase_q <= PH_XFER;
      endcase
    end
  end

  // R7: a drained pair returns to the transfer phase
  p_drain_exit_r7: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DRAIN && both_empty) |=> (phase_q == PH_XFER));
  // R2: the second queue is only filled before the fill phase starts
  p_fill_after_b_r2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_XFER && !b_full) |=> (phase_q == PH_XFER));
endmodule

// File: rtl/nib2byte_chain.sv
module nib2byte_chain
  import nbc_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [NIB_W-1:0]   wr_data,
  input  logic               rd_en,
  output logic [2*NIB_W-1:0] rd_data,
  output logic               full,
  output logic               empty
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int BW = 2 * NIB_W;

  logic [NIB_W-1:0] a_dout, b_dout;
  logic             a_full, a_empty, b_full, b_empty;
  logic [CW-1:0]    a_lvl, b_lvl;
  logic             a_push, move, pop_pair;
  nbc_phase_e       phase;
  logic [BW-1:0]    byte_q;

  nbc_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .wr_req   (wr_en),
    .rd_req   (rd_en),
    .a_full   (a_full),
    .a_empty  (a_empty),
    .b_full   (b_full),
    .b_empty  (b_empty),
    .a_push   (a_push),
    .move     (move),
    .pop_pair (pop_pair),
    .phase    (phase)
  );

  nbc_fifo #(.W(NIB_W), .DEPTH(DEPTH)) u_q_a (
    .clk   (clk),
    .rst   (rst),
    .push  (a_push),
    .din   (wr_data),
    .pop   (move || pop_pair),
    .dout  (a_dout),
    .full  (a_full),
    .empty (a_empty),
    .level (a_lvl)
  );

  nbc_fifo #(.W(NIB_W), .DEPTH(DEPTH)) u_q_b (
    .clk   (clk),
    .rst   (rst),
    .push  (move),
    .din   (a_dout),
    .pop   (pop_pair),
    .dout  (b_dout),
    .full  (b_full),
    .empty (b_empty),
    .level (b_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst)           byte_q <= '0;
    else if (pop_pair) byte_q <= {a_dout, b_dout};
  end

  assign rd_data = byte_q;
  assign full    = a_full && b_full;
  assign empty   = a_empty && b_empty;

  // R5: both queues drain in lockstep
  p_lockstep_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DRAIN) |-> (a_lvl == b_lvl));
  // R5: the output byte changes only on an accepted pair read
  p_byte_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !pop_pair |=> $stable(byte_q));
  // R4: no input nibble enters while a non-empty pair drains
  p_drain_no_write_r4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DRAIN && !empty) |=> (a_lvl <= $past(a_lvl)));
  // R2: the second queue never shrinks during transfer
  p_xfer_grows_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_XFER) |=> (b_lvl >= $past(b_lvl)));
endmodule

// File: tb/nib2byte_chain_tb_top.sv
module nib2byte_chain_tb_top;
  localparam int NW = 4;
  localparam int DP = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [NW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [7:0]    rd_data;
  logic          full, empty;
  int            n_chk = 0;
  int            n_bad = 0;

  always #4 clk = ~clk;

  nib2byte_chain #(.NIB_W(NW), .DEPTH(DP)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .full(full), .empty(empty)
  );

  // fields: wr[15] nib[14:11] rd[10] full[9] empty[8] byte[7:0]
  localparam logic [15:0] VEC [12] = '{
    {1'b1, 4'h1, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b1, 4'h2, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b1, 4'h3, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b1, 4'h4, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b1, 4'h5, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b1, 4'h6, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b1, 4'h7, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b1, 4'h8, 1'b0, 1'b1, 1'b0, 8'h00},
    {1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 8'h51},
    {1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 8'h62},
    {1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 8'h73},
    {1'b0, 4'h0, 1'b1, 1'b0, 1'b1, 8'h84}
  };

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic chk(input string req, input logic ef, input logic ee, input logic [7:0] eb);
    n_chk++;
    if (full !== ef || empty !== ee || rd_data !== eb) begin
      n_bad++;
      $display("FAIL %s: full=%0b empty=%0b byte=%h, expected full=%0b empty=%0b byte=%h",
               req, full, empty, rd_data, ef, ee, eb);
    end
  endtask

  // drive after a falling edge, one rising edge, sample at next falling edge
  task automatic cyc(input logic w, input logic [3:0] n, input logic r);
    wr_en = w; wr_data = n; rd_en = r;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 in reset", 1'b0, 1'b1, 8'h00);
    rst = 1'b0;
    cyc(1'b0, 4'h0, 1'b0);
    chk("R1 after reset", 1'b0, 1'b1, 8'h00);

    // table: back-to-back fill (R9, R3) then drain (R2, R5, R7)
    for (int i = 0; i < 12; i++) begin
      cyc(VEC[i][15], VEC[i][14:11], VEC[i][10]);
      chk($sformatf("R2/R3/R9 vector %0d", i), VEC[i][9], VEC[i][8], VEC[i][7:0]);
    end

    // R8: read while empty is ignored, byte held
    cyc(1'b0, 4'h0, 1'b1);
    chk("R8 read on empty", 1'b0, 1'b1, 8'h84);

    // R7: writes accepted at once after drain; refill with 9..F,0
    for (int i = 0; i < 2*DP; i++) begin
      cyc(1'b1, 4'(i + 9), 1'b0);
    end
    chk("R7 refill reaches full", 1'b1, 1'b0, 8'h84);

    // R4: write while full refused
    cyc(1'b1, 4'h5, 1'b0);
    chk("R4 write on full", 1'b1, 1'b0, 8'h84);
    cyc(1'b0, 4'h0, 1'b1);
    chk("R2 byte 0 of refill", 1'b0, 1'b0, 8'hD9);
    // R4: write during drain refused
    cyc(1'b1, 4'h3, 1'b0);
    chk("R4 write during drain", 1'b0, 1'b0, 8'hD9);
    cyc(1'b0, 4'h0, 1'b1);
    chk("R5 byte 1", 1'b0, 1'b0, 8'hEA);
    cyc(1'b0, 4'h0, 1'b1);
    chk("R5 byte 2", 1'b0, 1'b0, 8'hFB);
    cyc(1'b0, 4'h0, 1'b1);
    chk("R7 last byte sets empty", 1'b0, 1'b1, 8'h0C);

    // R7: first write right after the drain is accepted
    cyc(1'b1, 4'h1, 1'b0);
    chk("R7 write after drain", 1'b0, 1'b0, 8'h0C);
    cyc(1'b1, 4'h2, 1'b0);
    // R6: read before full is ignored
    cyc(1'b0, 4'h0, 1'b1);
    chk("R6 early read ignored", 1'b0, 1'b0, 8'h0C);
    for (int i = 3; i <= 2*DP - 1; i++) begin
      cyc(1'b1, 4'(i), 1'b0);
    end
    chk("R3 one short of full", 1'b0, 1'b0, 8'h0C);
    cyc(1'b1, 4'h8, 1'b0);
    chk("R3 full on last nibble", 1'b1, 1'b0, 8'h0C);
    cyc(1'b0, 4'h0, 1'b1);
    chk("R6 no nibble lost", 1'b0, 1'b0, 8'h51);

    // R1: reset in mid-stream clears everything
    rst = 1'b1;
    cyc(1'b0, 4'h0, 1'b0);
    rst = 1'b0;
    chk("R1 mid-stream reset", 1'b0, 1'b1, 8'h00);
    cyc(1'b0, 4'h0, 1'b1);
    chk("R1 nothing left after reset", 1'b0, 1'b1, 8'h00);

    summary();
    $finish;
  end
endmodule